// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File

This block holds the operand registers of a floating-point unit as a rotating stack. A top-of-stack pointer turns every relative operand index ST(i) into a physical entry, (top + i) mod DEPTH. Each entry carries a tag that marks it valid or empty. Add commands come in five forms. The block looks up the two operands of the form and hands them to an adder outside the block. It then takes the sum back, writes it into the chosen destination and, for the popping forms, retires the top of the stack. The block does no arithmetic of its own.

A small state machine sequences each command. It has four states:
- **IDLE**: accepts a command or a load.
- **BUSY**: presents the operands and waits for the sum. It returns to IDLE on the sum strobe.
- **UFLOW**: reports an operand that was empty. It lasts one cycle and returns to IDLE.
- **OFLOW**: reports a push into an entry that was already valid. It lasts one cycle and returns to IDLE.

The transitions out of IDLE are:
- A legal command whose sources are all valid goes to BUSY.
- A legal command with an empty source goes to UFLOW.
- An illegal command stays in IDLE.
- A load into an empty entry stays in IDLE.
- A load into a valid entry goes to OFLOW.

A load port pushes values onto the stack. It exists to set the stack up.

Top module: `fstack_rf`

## Requirements
- R1: After reset the top pointer is 0, every entry is tagged empty, `cmd_ready` is 1, and `op_valid`, `uflow_o` and `oflow_o` are 0.
- R2: For `rd_idx` = i, `rd_data` and `rd_tag` show the value and the tag of physical entry (top + i) mod DEPTH.
- R3: The block takes a load when `ld_valid` is 1, `cmd_valid` is 0 and it is in IDLE. If entry (top − 1) is empty, top becomes top − 1 (wrapping) and the new ST(0) holds `ld_data`, tagged valid. If that entry is already valid, nothing changes and `oflow_o` is 1 for one cycle, in the cycle after the load.
- R4: The block accepts a command when `cmd_valid` is 1 in IDLE. One cycle later `op_valid` rises. `op_a` shows the destination's current value and `op_b` the other operand. Both hold until the cycle in which `sum_valid` is 1. On that edge the sum is written into the destination, the destination is tagged valid, and the block returns to IDLE.
- R5: Form code 0 writes ST(0) + ST(i) into ST(0). With i = 0 this doubles ST(0).
- R6: Form code 1 writes ST(i) + ST(0) into ST(i) and does not move the top pointer.
- R7: Form code 2 writes ST(i) + ST(0) into ST(i). On the same edge it then pops: the entry that was ST(0) is tagged empty and top becomes top + 1 (wrapping). The empty tag wins when the destination is that same entry (i = 0).
- R8: Form code 3 writes ST(1) + ST(0) into ST(1) and pops, whatever the value of `cmd_idx`.
- R9: Form code 4 writes ST(0) + `cmd_ext` into ST(0).
- R10: If any register source of an accepted legal command is empty, the command is aborted. No value, tag or pointer changes, `op_valid` stays 0, and `uflow_o` is 1 for exactly one cycle, in the cycle after acceptance.
- R11: Form codes 5 to 7 are accepted and have no effect. No flag rises, `op_valid` stays 0 and the stack is unchanged.
- R12: When `cmd_valid` and `ld_valid` are both 1 in IDLE, the command is taken and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Add command strobe |
| cmd_form | input | 3 | Add form code, 0 to 4 (5 to 7 are illegal) |
| cmd_idx | input | IDX_W | Relative index i |
| cmd_ext | input | DATA_W | External operand for form code 4 |
| cmd_ready | output | 1 | Block is in IDLE |
| ld_valid | input | 1 | Push strobe |
| ld_data | input | DATA_W | Value to push |
| op_valid | output | 1 | Operands presented to the adder |
| op_a | output | DATA_W | Destination-side operand |
| op_b | output | DATA_W | Other operand |
| sum_valid | input | 1 | Sum returned by the adder |
| sum_data | input | DATA_W | Sum value |
| uflow_o | output | 1 | Stack underflow pulse |
| oflow_o | output | 1 | Stack overflow pulse |
| top_o | output | IDX_W | Current top pointer |
| rd_idx | input | IDX_W | Relative index to inspect |
| rd_data | output | DATA_W | Value of ST(rd_idx) |
| rd_tag | output | 1 | Tag of ST(rd_idx), 1 = valid |

## Verification
The bench builds the block with DATA_W = 16 and DEPTH = 8. With 16-bit values, the integer sums computed by the bench wrap in the same way as the operand ports. Eight entries are few enough that a handful of pushes and pops carries the top pointer across the 7-to-0 boundary and fills the stack until the overflow path fires. Varying the adder's response latency exercises the BUSY hold.

// File: rtl/fstack_pkg.sv
package fstack_pkg;
    typedef enum logic [2:0] {
        FORM_ST0_STI = 3'd0,
        FORM_STI_ST0 = 3'd1,
        FORM_STI_POP = 3'd2,
        FORM_ST1_POP = 3'd3,
        FORM_ST0_EXT = 3'd4
    } form_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BUSY  = 2'd1,
        S_UFLOW = 2'd2,
        S_OFLOW = 2'd3
    } state_e;
endpackage

// File: rtl/fstack_decode.sv
module fstack_decode #(
    parameter int IDX_W = 3
) (
    input  logic [2:0]       form_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             legal_o,
    output logic [IDX_W-1:0] dst_rel_o,
    output logic [IDX_W-1:0] oth_rel_o,
    output logic             oth_ext_o,
    output logic             pop_o
);
    import fstack_pkg::*;

    always_comb begin
        legal_o   = 1'b1;
        dst_rel_o = '0;
        oth_rel_o = '0;
        oth_ext_o = 1'b0;
        pop_o     = 1'b0;
        unique case (form_e'(form_i))
            FORM_ST0_STI: oth_rel_o = idx_i;
            FORM_STI_ST0: dst_rel_o = idx_i;
            FORM_STI_POP: begin
                dst_rel_o = idx_i;
                pop_o     = 1'b1;
            end
            FORM_ST1_POP: begin
                dst_rel_o = IDX_W'(1);
                pop_o     = 1'b1;
            end
            FORM_ST0_EXT: oth_ext_o = 1'b1;
            default:      legal_o   = 1'b0;
        endcase
    end
endmodule

// File: rtl/fstack_store.sv
module fstack_store #(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 8,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] rc_data,
    output logic [DEPTH-1:0]  tags_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [DATA_W-1:0] val_q;
        logic              tag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
                tag_q <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(e)) begin
                    val_q <= wr_data;
                    tag_q <= 1'b1;
                end
                // the pop clear overrides a write to the same entry
                if (clr_en && clr_idx == IDX_W'(e)) tag_q <= 1'b0;
            end
        end

        assign mem[e]    = val_q;
        assign tags_o[e] = tag_q;
    end

    assign ra_data = mem[ra_idx];
    assign rb_data = mem[rb_idx];
    assign rc_data = mem[rc_idx];
endmodule

// File: rtl/fstack_rf.sv
module fstack_rf #(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 8,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_form,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_ext,
    output logic              cmd_ready,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    output logic              op_valid,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    input  logic              sum_valid,
    input  logic [DATA_W-1:0] sum_data,
    output logic              uflow_o,
    output logic              oflow_o,
    output logic [IDX_W-1:0]  top_o,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_tag
);
    import fstack_pkg::*;

    state_e            state_q, state_d;
    logic [IDX_W-1:0]  top_q, wb_idx_q;
    logic              pop_q;
    logic [DATA_W-1:0] opa_q, opb_q;

    logic              legal, oth_ext, do_pop;
    logic [IDX_W-1:0]  dst_rel, oth_rel, dst_phys, oth_phys, push_phys, rd_phys;
    logic [DATA_W-1:0] ra_data, rb_data;
    logic [DEPTH-1:0]  tags;
    logic              src_empty, push_full, take_cmd, take_ld, do_push, do_wb;

    fstack_decode #(.IDX_W(IDX_W)) u_dec (
        .form_i    (cmd_form),
        .idx_i     (cmd_idx),
        .legal_o   (legal),
        .dst_rel_o (dst_rel),
        .oth_rel_o (oth_rel),
        .oth_ext_o (oth_ext),
        .pop_o     (do_pop)
    );

    assign dst_phys  = top_q + dst_rel;
    assign oth_phys  = top_q + oth_rel;
    assign push_phys = top_q - IDX_W'(1);
    assign rd_phys   = top_q + rd_idx;

    assign src_empty = !tags[dst_phys] || (!oth_ext && !tags[oth_phys]);
    assign push_full = tags[push_phys];
    assign take_cmd  = (state_q == S_IDLE) && cmd_valid;
    assign take_ld   = (state_q == S_IDLE) && !cmd_valid && ld_valid;
    assign do_push   = take_ld && !push_full;
    assign do_wb     = (state_q == S_BUSY) && sum_valid;

    fstack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_wb || do_push),
        .wr_idx  (do_wb ? wb_idx_q : push_phys),
        .wr_data (do_wb ? sum_data : ld_data),
        .clr_en  (do_wb && pop_q),
        .clr_idx (top_q),
        .ra_idx  (dst_phys),
        .rb_idx  (oth_phys),
        .rc_idx  (rd_phys),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .rc_data (rd_data),
        .tags_o  (tags)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (legal) state_d = src_empty ? S_UFLOW : S_BUSY;
                end else if (ld_valid && push_full) begin
                    state_d = S_OFLOW;
                end
            end
            S_BUSY:  if (sum_valid) state_d = S_IDLE;
            S_UFLOW: state_d = S_IDLE;
            S_OFLOW: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // pointer and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q    <= '0;
            wb_idx_q <= '0;
            pop_q    <= 1'b0;
            opa_q    <= '0;
            opb_q    <= '0;
        end else begin
            if (take_cmd && legal && !src_empty) begin
                wb_idx_q <= dst_phys;
                pop_q    <= do_pop;
                opa_q    <= ra_data;
                opb_q    <= oth_ext ? cmd_ext : rb_data;
            end
            if (do_push)             top_q <= push_phys;
            else if (do_wb && pop_q) top_q <= top_q + IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        op_valid  = (state_q == S_BUSY);
        uflow_o   = (state_q == S_UFLOW);
        oflow_o   = (state_q == S_OFLOW);
        op_a      = opa_q;
        op_b      = opb_q;
        top_o     = top_q;
        rd_tag    = tags[rd_phys];
    end
endmodule

// File: rtl/fstack_chk.sv
module fstack_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              ld_valid,
    input logic              op_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              sum_valid,
    input logic              uflow_o,
    input logic              oflow_o,
    input logic [IDX_W-1:0]  top_o
);
    AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sum_valid) |=> (op_valid && $stable(op_a) && $stable(op_b))); // R4

    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && sum_valid) |=> cmd_ready); // R4

    AST_PUSH_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && ld_valid && !cmd_valid) |=> (oflow_o || top_o == IDX_W'($past(top_o) - 1'b1))); // R3

    AST_OFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        oflow_o |=> cmd_ready); // R3

    AST_UFLOW_KEEP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_o |-> (top_o == $past(top_o))); // R10

    AST_UFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_o |=> !uflow_o); // R10

    AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid) |=> (top_o == $past(top_o))); // R12
endmodule

bind fstack_rf fstack_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/fstack_rf_tb.sv
module fstack_rf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int DEP = 8;
    localparam int IW = 3;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, ld_valid = 0, sum_valid = 0;
    logic [2:0] cmd_form = 0;
    logic [IW-1:0] cmd_idx = 0, rd_idx = 0, top_o;
    logic [DW-1:0] cmd_ext = 0, ld_data = 0, sum_data = 0, op_a, op_b, rd_data;
    logic cmd_ready, op_valid, uflow_o, oflow_o, rd_tag;

    int n_run = 0, n_fail = 0, resp_lat = 0, wait_cnt = 0;
    logic [2*DW-1:0] exp_q[$];
    logic [DW-1:0] m_val [DEP];
    logic          m_tag [DEP];
    logic [IW-1:0] m_top;

    always #(CLK_PERIOD/2) clk = ~clk;

    fstack_rf #(.DATA_W(DW), .DEPTH(DEP)) dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected operand pairs and returns the sum
    always @(negedge clk) begin
        if (sum_valid) begin
            sum_valid = 0;
        end else if (op_valid) begin
            if (wait_cnt < resp_lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                if (exp_q.size() == 0) check("R4 unexpected operands", 1, 0);
                else check("R4 operands", {op_a, op_b}, exp_q.pop_front());
                sum_data  = op_a + op_b;
                sum_valid = 1;
            end
        end
    end

    task automatic check_stack(input string req);
        check({req, " top"}, top_o, m_top);
        for (int i = 0; i < DEP; i++) begin
            logic [IW-1:0] p;
            p = m_top + IW'(i);
            rd_idx = IW'(i);
            #1;
            check({req, " R2 tag"}, rd_tag, m_tag[p]);
            if (m_tag[p]) check({req, " R2 data"}, rd_data, m_val[p]);
        end
    endtask

    task automatic push(input logic [DW-1:0] v);
        logic [IW-1:0] p;
        logic ov;
        p  = m_top - 1'b1;
        ov = m_tag[p];
        @(negedge clk);
        ld_valid = 1; ld_data = v;
        @(negedge clk);
        ld_valid = 0;
        check("R3 oflow", oflow_o, ov);
        if (ov) @(negedge clk);
        else begin m_top = p; m_val[p] = v; m_tag[p] = 1; end
        check_stack("R3");
    endtask

    task automatic add(input string req, input logic [2:0] f, input logic [IW-1:0] i,
                       input logic [DW-1:0] ext, input logic with_ld, input int lat);
        logic legal, isext, pop, uf;
        logic [IW-1:0] dr, orl, dp, op;
        logic [DW-1:0] va, vb;
        int guard;
        legal = (f <= 3'd4);
        dr = (f == 3'd1 || f == 3'd2) ? i : (f == 3'd3) ? IW'(1) : IW'(0);
        orl = (f == 3'd0) ? i : IW'(0);
        isext = (f == 3'd4);
        pop = (f == 3'd2 || f == 3'd3);
        dp = m_top + dr; op = m_top + orl;
        uf = legal && (!m_tag[dp] || (!isext && !m_tag[op]));
        va = m_val[dp]; vb = isext ? ext : m_val[op];
        if (legal && !uf) exp_q.push_back({va, vb});
        resp_lat = lat;
        @(negedge clk);
        cmd_valid = 1; cmd_form = f; cmd_idx = i; cmd_ext = ext;
        ld_valid = with_ld; ld_data = 16'hdead;
        @(negedge clk);
        cmd_valid = 0; ld_valid = 0;
        check({req, " R10 uflow"}, uflow_o, uf);
        check({req, " op_valid"}, op_valid, legal && !uf);
        guard = 0;
        while (!cmd_ready && guard < 50) begin @(negedge clk); guard++; end
        if (legal && !uf) begin
            m_val[dp] = va + vb; m_tag[dp] = 1;
            if (pop) begin m_tag[m_top] = 0; m_top = m_top + 1'b1; end
        end
        check({req, " queue drained"}, exp_q.size(), 0);
        check_stack(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        m_top = 0;
        for (int k = 0; k < DEP; k++) begin m_val[k] = 0; m_tag[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 ready", cmd_ready, 1);
        check("R1 flags", {op_valid, uflow_o, oflow_o}, 0);
        check_stack("R1");
        add("R10 empty", 3'd0, 3'd1, 0, 0, 0);
        push(16'd10); push(16'd20); push(16'd30);
        add("R5 st0+st2", 3'd0, 3'd2, 0, 0, 0);
        add("R5 double", 3'd0, 3'd0, 0, 0, 1);
        add("R6 st1+st0", 3'd1, 3'd1, 0, 0, 0);
        add("R9 ext", 3'd4, 3'd6, 16'd5, 0, 2);
        add("R10 st5 empty", 3'd1, 3'd5, 0, 0, 0);
        add("R11 code6", 3'd6, 3'd1, 0, 0, 0);
        add("R11 code5", 3'd5, 3'd0, 0, 0, 0);
        add("R12 cmd+ld", 3'd0, 3'd1, 0, 1, 0);
        add("R7 pop st2", 3'd2, 3'd2, 0, 0, 3);
        add("R8 pop st1", 3'd3, 3'd5, 0, 0, 1);
        for (int k = 0; k < 8; k++) push(16'(100 + k));
        add("R7 pop self", 3'd2, 3'd0, 0, 0, 0);
        add("R8 wrap", 3'd3, 3'd0, 0, 0, 0);
        push(16'd7);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule